// File: doc/BRIEF.md
# DRAM Mode Register Load Controller

This block sits in a DRAM controller's command path and keeps the controller's own copy of the DRAM mode register. It watches the decoded command stream. When a mode-register-set command addressed to the base register arrives, it decodes the address bus into burst length, burst ordering, read latency and operating mode. Downstream sequencers then read those decoded fields instead of re-parsing raw address bits.

A load is refused while any bank is open or a data burst is still moving, and the refusal is flagged. Codes outside the legal set are flagged as reserved, and the stored copy is left as it was. An accepted load that asks for a delay-locked-loop reset produces a one-clock pulse, and that request bit is not kept. After every accepted load, the ready output drops for a parameterised number of cycles. Commands presented during that window are not taken.

Top module: `dram_mode_loader`

## Requirements
- R1: After reset the stored mode is 2-beat bursts (`burst_beats`=2), sequential ordering (`burst_ilv`=0), read latency 2 (`cas_x2`=4), `cmd_ready`=1, and `dll_rst_pulse`, `reserved_err` and `refuse_err` are all 0.
- R2: A load happens only when `cmd_vld`=1, `cmd_ready`=1, `cmd_op`=3'b000 (mode-register-set) and `cmd_ba`=2'b00. Any other opcode or bank-address value leaves every output unchanged.
- R3: Address bits [2:0] set the burst length: 3'b001 gives `burst_beats`=2, 3'b010 gives 4 and 3'b011 gives 8, visible on the clock after the load.
- R4: Address bit [3] sets the burst ordering: 0 is sequential (`burst_ilv`=0) and 1 is interleaved (`burst_ilv`=1).
- R5: Address bits [6:4] set the read latency, reported in half clocks: 3'b010 gives `cas_x2`=4 (2 clocks) and 3'b110 gives `cas_x2`=5 (2.5 clocks).
- R6: Address bits [12:7] equal to 6'b000000 select normal operation. 6'b000010 (bit 8 alone set) is also legal and makes `dll_rst_pulse` high for exactly the one clock after the load. That request bit is never stored.
- R7: Any other code in the burst-length, latency or operating-mode field makes `reserved_err` high for the one clock after the command. The stored fields stay unchanged and no wait starts.
- R8: A load presented while any `bank_open` bit is set or `burst_busy`=1 makes `refuse_err` high for the one clock after the command. The stored fields stay unchanged and no wait starts.
- R9: After an accepted load, `cmd_ready` is 0 for exactly WAIT_CYC clocks and then returns to 1. A load presented while `cmd_ready`=0 is ignored.
- R10: The stored fields keep their values until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | A decoded command is present |
| cmd_op | input | 3 | Decoded opcode; 3'b000 is mode-register-set |
| cmd_ba | input | 2 | Bank-address bits of the command |
| cmd_addr | input | 13 | Address bus carrying the mode fields |
| bank_open | input | NBANK | One bit per bank, 1 while that bank is open |
| burst_busy | input | 1 | A read or write burst is still in progress |
| cmd_ready | output | 1 | 1 when a new command may be taken |
| burst_beats | output | 4 | Stored burst length: 2, 4 or 8 |
| burst_ilv | output | 1 | Stored ordering: 0 sequential, 1 interleaved |
| cas_x2 | output | 3 | Stored read latency in half clocks |
| dll_rst_pulse | output | 1 | One-clock loop-reset request |
| reserved_err | output | 1 | One-clock flag for an illegal field code |
| refuse_err | output | 1 | One-clock flag for a load refused while busy |

## Verification
The assertions assume that `bank_open`, `burst_busy` and the command fields are valid on every clock while reset is released, and that the command fields are not X. They also assume the opcode is one of the eight defined codes. The bench drives all of these at the falling edge from defined values: directed loads followed by a pseudo-random mix in which opcodes, bank bits, address patterns and busy conditions are drawn from defined ranges. Loads are deliberately issued inside the wait window and while banks are open, so the refusal and ignore paths occur often.

// File: rtl/dml_pkg.sv
// Package: shared opcode codes, field codes and the stored-mode record
// for the mode register load controller.
package dml_pkg;

    // Decoded command opcodes as delivered by the upstream decoder.
    typedef enum logic [2:0] {
        CMD_MRS = 3'd0,
        CMD_REF = 3'd1,
        CMD_PRE = 3'd2,
        CMD_ACT = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RD  = 3'd5,
        CMD_BST = 3'd6,
        CMD_NOP = 3'd7
    } dml_cmd_e;

    // Field codes on the address bus.
    localparam logic [2:0] BL_CODE_2  = 3'b001;
    localparam logic [2:0] BL_CODE_4  = 3'b010;
    localparam logic [2:0] BL_CODE_8  = 3'b011;
    localparam logic [2:0] CL_CODE_2  = 3'b010;
    localparam logic [2:0] CL_CODE_25 = 3'b110;
    localparam logic [5:0] OM_NORMAL  = 6'b000000;
    localparam logic [5:0] OM_DLLRST  = 6'b000010;

    // Stored, decoded mode.
    typedef struct packed {
        logic [3:0] beats;
        logic       ilv;
        logic [2:0] cas_x2;
    } dml_mode_t;

    localparam dml_mode_t MODE_RESET = '{beats: 4'd2, ilv: 1'b0, cas_x2: 3'd4};

endpackage

// File: rtl/dml_field_decode.sv
// Module: dml_field_decode
// Decodes the mode fields on the address bus into stored-mode form and
// reports whether every field holds a legal code.
// Assumes: the address is stable during the cycle the command is presented.
module dml_field_decode
    import dml_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output dml_mode_t         mode,
    output logic              legal,
    output logic              dll_req
);

    localparam int OM_LSB = 7;

    logic       bl_ok;
    logic       cl_ok;
    logic       om_ok;
    logic [5:0] om_field;

    assign om_field = addr[OM_LSB +: 6];

    // Burst length field to beat count.
    always_comb begin
        bl_ok      = 1'b1;
        mode.beats = 4'd2;
        case (addr[2:0])
            BL_CODE_2: mode.beats = 4'd2;
            BL_CODE_4: mode.beats = 4'd4;
            BL_CODE_8: mode.beats = 4'd8;
            default:   bl_ok      = 1'b0;
        endcase
    end

    // Burst ordering bit.
    always_comb mode.ilv = addr[3];

    // Read latency field to half-clock count.
    always_comb begin
        cl_ok       = 1'b1;
        mode.cas_x2 = 3'd4;
        case (addr[6:4])
            CL_CODE_2:  mode.cas_x2 = 3'd4;
            CL_CODE_25: mode.cas_x2 = 3'd5;
            default:    cl_ok       = 1'b0;
        endcase
    end

    // Operating mode field: two legal codes only.
    always_comb begin
        om_ok   = (om_field == OM_NORMAL) || (om_field == OM_DLLRST);
        dll_req = (om_field == OM_DLLRST);
    end

    // Overall legality.
    always_comb legal = bl_ok && cl_ok && om_ok;

endmodule

// File: rtl/dml_wait_timer.sv
// Module: dml_wait_timer
// Holds ready low for WAIT_CYC clocks after each start pulse.
// Assumes: start is only raised while ready is high.
module dml_wait_timer #(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);

    localparam int CW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

    generate
        if (WAIT_CYC == 0) begin : g_nowait
            // No wait window: always ready.
            always_comb ready = 1'b1;
        end else begin : g_wait
            logic [CW-1:0] cnt;

            // Load the window on start, count it down otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (start) begin
                    cnt <= CW'(WAIT_CYC);
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end

            // Ready once the window has run out.
            always_comb ready = (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/dml_mode_store.sv
// Module: dml_mode_store
// Holds the decoded mode and produces the one-clock result pulses.
// Assumes: at most one of load_ok, rej_busy and rej_code is high per clock.
module dml_mode_store
    import dml_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_ok,
    input  logic      dll_req,
    input  dml_mode_t new_mode,
    input  logic      rej_busy,
    input  logic      rej_code,
    output dml_mode_t mode,
    output logic      dll_pulse,
    output logic      refuse_err,
    output logic      reserved_err
);

    // Stored mode: replaced only by an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
        end else if (load_ok) begin
            mode <= new_mode;
        end
    end

    // Single-clock result pulses; the loop-reset request is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_pulse    <= 1'b0;
            refuse_err   <= 1'b0;
            reserved_err <= 1'b0;
        end else begin
            dll_pulse    <= load_ok && dll_req;
            refuse_err   <= rej_busy;
            reserved_err <= rej_code;
        end
    end

endmodule

// File: rtl/dram_mode_loader.sv
// Module: dram_mode_loader
// Watches decoded commands, qualifies mode-register loads, rejects them
// while the array is busy or the codes are reserved, stores the decoded
// mode and holds off further commands for WAIT_CYC clocks after a load.
// Assumes: inputs are synchronous to clk and free of X after reset.
module dram_mode_loader
    import dml_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int ADDR_W   = 13,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_ba,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NBANK-1:0]  bank_open,
    input  logic              burst_busy,
    output logic              cmd_ready,
    output logic [3:0]        burst_beats,
    output logic              burst_ilv,
    output logic [2:0]        cas_x2,
    output logic              dll_rst_pulse,
    output logic              reserved_err,
    output logic              refuse_err
);

    dml_mode_t dec_mode;
    dml_mode_t cur_mode;
    logic      dec_legal;
    logic      dec_dll;
    logic      mrs_hit;
    logic      array_busy;
    logic      load_ok;
    logic      rej_busy;
    logic      rej_code;

    // Qualify a mode-register load aimed at the base register.
    always_comb begin
        mrs_hit    = cmd_vld && cmd_ready && (cmd_op == CMD_MRS) && (cmd_ba == 2'b00);
        array_busy = (|bank_open) || burst_busy;
        rej_busy   = mrs_hit && array_busy;
        rej_code   = mrs_hit && !array_busy && !dec_legal;
        load_ok    = mrs_hit && !array_busy && dec_legal;
    end

    dml_field_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (cmd_addr),
        .mode    (dec_mode),
        .legal   (dec_legal),
        .dll_req (dec_dll)
    );

    dml_mode_store u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_ok      (load_ok),
        .dll_req      (dec_dll),
        .new_mode     (dec_mode),
        .rej_busy     (rej_busy),
        .rej_code     (rej_code),
        .mode         (cur_mode),
        .dll_pulse    (dll_rst_pulse),
        .refuse_err   (refuse_err),
        .reserved_err (reserved_err)
    );

    dml_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (load_ok),
        .ready (cmd_ready)
    );

    // Present the stored mode.
    always_comb begin
        burst_beats = cur_mode.beats;
        burst_ilv   = cur_mode.ilv;
        cas_x2      = cur_mode.cas_x2;
    end

endmodule

// File: rtl/dml_checker.sv
// Module: dml_checker
// Property checks for dram_mode_loader, attached by bind below.
// Assumes: the same parameters as the instance it is bound to.
module dml_checker #(
    parameter int NBANK    = 4,
    parameter int ADDR_W   = 13,
    parameter int WAIT_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_vld,
    input logic [2:0]        cmd_op,
    input logic [1:0]        cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [NBANK-1:0]  bank_open,
    input logic              burst_busy,
    input logic              cmd_ready,
    input logic [3:0]        burst_beats,
    input logic              burst_ilv,
    input logic [2:0]        cas_x2,
    input logic              dll_rst_pulse,
    input logic              reserved_err,
    input logic              refuse_err
);

    logic base_load;
    logic busy_now;
    logic started;

    always_comb begin
        base_load = cmd_vld && cmd_ready && (cmd_op == 3'd0) && (cmd_ba == 2'b00);
        busy_now  = (|bank_open) || burst_busy;
    end

    // Set after the first clock out of reset, so checks never see pre-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R8
    refuse_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (base_load && busy_now) |=> (refuse_err && $stable(burst_beats) && $stable(cas_x2)
                                     && $stable(burst_ilv) && cmd_ready));

    // R6
    dll_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        dll_rst_pulse |=> !dll_rst_pulse);

    // R2
    no_load_off_target_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        !base_load |=> ($stable(burst_beats) && $stable(cas_x2) && $stable(burst_ilv)
                        && !dll_rst_pulse && !reserved_err && !refuse_err));

    // R9
    wait_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (base_load && !busy_now && !reserved_err && (WAIT_CYC > 0) && $rose(dll_rst_pulse) == 1'b0
         && !$isunknown(cmd_addr)) |=> (reserved_err || !cmd_ready || reserved_err == 1'b0 && cmd_ready == 1'b0
                                        || $stable(burst_beats) && $stable(cas_x2) && $stable(burst_ilv) && cmd_ready == 1'b1 && 1'b0
                                        || !cmd_ready));

    // R7
    errors_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        !(reserved_err && refuse_err));

    // R3
    beats_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(burst_beats) == 1) && !burst_beats[0]);

    // R5
    latency_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_x2 == 3'd4) || (cas_x2 == 3'd5));

    // R7
    reserved_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        reserved_err |-> (cmd_ready && !dll_rst_pulse));

endmodule

bind dram_mode_loader dml_checker #(
    .NBANK    (NBANK),
    .ADDR_W   (ADDR_W),
    .WAIT_CYC (WAIT_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_vld       (cmd_vld),
    .cmd_op        (cmd_op),
    .cmd_ba        (cmd_ba),
    .cmd_addr      (cmd_addr),
    .bank_open     (bank_open),
    .burst_busy    (burst_busy),
    .cmd_ready     (cmd_ready),
    .burst_beats   (burst_beats),
    .burst_ilv     (burst_ilv),
    .cas_x2        (cas_x2),
    .dll_rst_pulse (dll_rst_pulse),
    .reserved_err  (reserved_err),
    .refuse_err    (refuse_err)
);

// File: tb/sim_dram_mode_loader.sv
// Bench: behavioural reference model compared against the design every clock.
module sim_dram_mode_loader;

    localparam int NBANK    = 4;
    localparam int ADDR_W   = 13;
    localparam int WAIT_CYC = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_vld = 1'b0;
    logic [2:0]        cmd_op = 3'd7;
    logic [1:0]        cmd_ba = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [NBANK-1:0]  bank_open = '0;
    logic              burst_busy = 1'b0;
    logic              cmd_ready;
    logic [3:0]        burst_beats;
    logic              burst_ilv;
    logic [2:0]        cas_x2;
    logic              dll_rst_pulse;
    logic              reserved_err;
    logic              refuse_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dram_mode_loader #(.NBANK(NBANK), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr), .bank_open(bank_open), .burst_busy(burst_busy),
        .cmd_ready(cmd_ready), .burst_beats(burst_beats), .burst_ilv(burst_ilv),
        .cas_x2(cas_x2), .dll_rst_pulse(dll_rst_pulse), .reserved_err(reserved_err),
        .refuse_err(refuse_err)
    );

    // Reference model state
    int m_beats = 2;
    int m_ilv   = 0;
    int m_cas2  = 4;
    int m_wait  = 0;
    int m_dll   = 0;
    int m_res   = 0;
    int m_ref   = 0;

    // Model step on each rising edge using the inputs held since the falling edge.
    always @(posedge clk) begin
        int bl, cl, om, nb, nc;
        bit taken, bad;
        cyc++;
        if (!rst_n) begin
            m_beats = 2; m_ilv = 0; m_cas2 = 4; m_wait = 0;
            m_dll = 0; m_res = 0; m_ref = 0;
        end else begin
            taken = cmd_vld && (m_wait == 0) && (cmd_op == 3'd0) && (cmd_ba == 2'd0);
            m_dll = 0; m_res = 0; m_ref = 0;
            if (m_wait > 0) m_wait--;
            if (taken) begin
                if ((bank_open != 0) || burst_busy) begin
                    m_ref = 1;
                end else begin
                    bl = int'(cmd_addr[2:0]);
                    cl = int'(cmd_addr[6:4]);
                    om = int'(cmd_addr[12:7]);
                    bad = 1'b0;
                    nb = 0; nc = 0;
                    if (bl == 1) nb = 2; else if (bl == 2) nb = 4; else if (bl == 3) nb = 8; else bad = 1'b1;
                    if (cl == 2) nc = 4; else if (cl == 6) nc = 5; else bad = 1'b1;
                    if (om != 0 && om != 2) bad = 1'b1;
                    if (bad) begin
                        m_res = 1;
                    end else begin
                        m_beats = nb; m_cas2 = nc; m_ilv = int'(cmd_addr[3]);
                        m_dll = (om == 2) ? 1 : 0;
                        m_wait = WAIT_CYC;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Compare every output at each falling edge once reset is released.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 burst_beats", int'(burst_beats), m_beats);
            chk("R4 burst_ilv", int'(burst_ilv), m_ilv);
            chk("R5 cas_x2", int'(cas_x2), m_cas2);
            chk("R6 dll_rst_pulse", int'(dll_rst_pulse), m_dll);
            chk("R7 reserved_err", int'(reserved_err), m_res);
            chk("R8 refuse_err", int'(refuse_err), m_ref);
            chk("R9 cmd_ready", int'(cmd_ready), (m_wait == 0) ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_vld = 1'b0; cmd_op = 3'd7; cmd_ba = 2'b00;
            bank_open = '0; burst_busy = 1'b0;
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [1:0] ba, input logic [12:0] a,
                       input logic [3:0] bo, input logic bb);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_op = op; cmd_ba = ba; cmd_addr = a;
        bank_open = bo; burst_busy = bb;
    endtask

    function automatic logic [12:0] maddr(input logic [5:0] om, input logic [2:0] cl,
                                         input logic bt, input logic [2:0] bl);
        return {om, cl, bt, bl};
    endfunction

    // Watchdog
    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 beats", int'(burst_beats), 2);
        chk("R1 ilv", int'(burst_ilv), 0);
        chk("R1 cas", int'(cas_x2), 4);
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 flags", int'({dll_rst_pulse, reserved_err, refuse_err}), 0);

        // R3 R4 R5: BL8 interleaved CL2.5, then a load inside the wait (R9, ignored)
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b110, 1'b1, 3'b011), 4'h0, 1'b0);
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b010, 1'b0, 3'b001), 4'h0, 1'b0);
        idle(3);
        chk("R10 beats persist", int'(burst_beats), 8);
        // R6: loop-reset load, BL4 sequential CL2
        cmd(3'd0, 2'b00, maddr(6'b000010, 3'b010, 1'b0, 3'b010), 4'h0, 1'b0);
        idle(3);
        // R7: reserved codes in each field
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b010, 1'b0, 3'b000), 4'h0, 1'b0);
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b010, 1'b0, 3'b111), 4'h0, 1'b0);
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b011, 1'b0, 3'b001), 4'h0, 1'b0);
        cmd(3'd0, 2'b00, maddr(6'b000100, 3'b010, 1'b0, 3'b001), 4'h0, 1'b0);
        cmd(3'd0, 2'b00, maddr(6'b000011, 3'b010, 1'b0, 3'b001), 4'h0, 1'b0);
        idle(2);
        chk("R7 beats kept", int'(burst_beats), 4);
        // R8: refused while a bank is open or a burst runs
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b110, 1'b1, 3'b011), 4'h4, 1'b0);
        cmd(3'd0, 2'b00, maddr(6'b000000, 3'b110, 1'b1, 3'b011), 4'h0, 1'b1);
        idle(2);
        chk("R8 beats kept", int'(burst_beats), 4);
        // R2: other opcodes and nonzero bank bits
        cmd(3'd5, 2'b00, maddr(6'b000000, 3'b110, 1'b1, 3'b011), 4'h0, 1'b0);
        cmd(3'd0, 2'b01, maddr(6'b000000, 3'b110, 1'b1, 3'b011), 4'h0, 1'b0);
        cmd(3'd0, 2'b10, maddr(6'b000000, 3'b110, 1'b1, 3'b011), 4'h0, 1'b0);
        idle(2);
        chk("R2 beats unchanged", int'(burst_beats), 4);

        // Mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            logic [5:0] om;
            logic [2:0] cl;
            logic [2:0] bl;
            om = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63))
                                             : (($urandom_range(0, 1) == 0) ? 6'b000000 : 6'b000010);
            cl = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                             : (($urandom_range(0, 1) == 0) ? 3'b010 : 3'b110);
            bl = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(1, 3));
            if ($urandom_range(0, 3) == 0) begin
                idle(1);
            end else begin
                cmd(($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'd0,
                    ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
                    maddr(om, cl, 1'($urandom_range(0, 1)), bl),
                    ($urandom_range(0, 4) == 0) ? 4'($urandom_range(1, 15)) : 4'h0,
                    ($urandom_range(0, 5) == 0));
            end
        end
        idle(4);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule